// File: doc/BRIEF.md
# Byte Transfer Down-Counter with Paired Host Address

This block tracks how many bytes of a bus transfer are still outstanding and which host address the next byte belongs to. Software loads a 24-bit remaining count and a 32-bit host address one byte at a time through a small register port. Each qualified byte-completion strobe does two things: it decrements the count by one and advances the address by one. The strobe is raised only after a byte has actually been moved, never when a move is only requested.

Two sticky status flags record the count reaching zero ("done") and the count underflowing past zero ("wrap"). Software clears them by writing ones to a status register. A maskable interrupt output reports either flag. The bus handshake, the FIFOs and the DMA engines are outside this block. It sees only the completion strobe.

Top module: `xfer_count_unit`

## Requirements
- R1: Register map, 8-bit data. Offsets 0, 1 and 2 hold count bytes, least significant at offset 0. Offsets 4 to 7 hold address bytes, least significant at offset 4. Each byte reads back what was last written, unless a strobe has moved it since.
- R2: A strobe that is accepted decrements the count by exactly one in the cycle after it. Without a strobe, and without a software load, the count holds its value.
- R3: When an accepted strobe takes the count from 1 to 0, the done flag (status bit 0) is set.
- R4: An accepted strobe while the count is 0 makes the count 0xFFFFFF and sets the wrap flag (status bit 1).
- R5: The address increments by one, modulo 2^32, on exactly those cycles where the count decrements.
- R6: A strobe is ignored by both count and address in any cycle that writes a count byte, writes an address byte, or clears the count.
- R7: Writing the control register (offset 3) with bit 0 set clears the count to zero. Writing bit 0 as 0 leaves the count alone.
- R8: Writing the status register (offset 8) with a 1 in a bit position clears that flag. A 0 in a bit position leaves that flag unchanged.
- R9: If a flag-setting event and a clearing write for that flag fall in the same cycle, the flag ends up set.
- R10: In the cycle after any count byte load or count clear, done is recomputed as (count == 0). This can both set and clear done.
- R11: `irq` = (done AND control bit 1) OR (wrap AND control bit 2).
- R12: After reset the count, the address, both flags and both enables are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write enable for this cycle |
| reg_addr | input | 4 | Register offset for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| byte_done | input | 1 | One pulse per byte safely transferred |
| irq | output | 1 | Masked interrupt from the done and wrap flags |

## Verification
Two events can coincide in one cycle. The first is a completion strobe arriving in the same cycle as a software write. The bench provokes this by raising `byte_done` on the same falling edge that sets up a count-byte write, and again with an address-byte write. It then reads both registers back and expects the written value, with no decrement and no increment. The second is an underflow strobe arriving in the same cycle as a status write that clears the wrap flag. The bench provokes this and expects the wrap flag still set and the count at 0xFFFFFF.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
  localparam int BYTE_W   = 8;
  localparam int ST_DONE  = 0;
  localparam int ST_WRAP  = 1;
  localparam int CTL_CLR  = 0;
  localparam int CTL_DIE  = 1;
  localparam int CTL_WIE  = 2;
  localparam int NUM_FLAG = 2;
endpackage

// File: rtl/xcu_counter.sv
module xcu_counter
  import xcu_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int ADR_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CNT_BYTES-1:0]        cnt_we,
  input  logic [ADR_BYTES-1:0]        adr_we,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        cnt_clr,
  input  logic                        strobe,
  output logic [CNT_BYTES*BYTE_W-1:0] cnt,
  output logic [CNT_BYTES*BYTE_W-1:0] cnt_nxt,
  output logic [ADR_BYTES*BYTE_W-1:0] adr,
  output logic                        dec_evt,
  output logic                        hit_zero,
  output logic                        underflow
);
  localparam int CW   = CNT_BYTES * BYTE_W;
  localparam int AWID = ADR_BYTES * BYTE_W;

  function automatic logic [CW-1:0] count_down(input logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  function automatic logic [AWID-1:0] addr_up(input logic [AWID-1:0] v);
    return v + AWID'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_put(input logic [CW-1:0] v, input int idx,
                                            input logic [BYTE_W-1:0] b);
    logic [CW-1:0] r;
    r = v;
    r[idx*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  function automatic logic [AWID-1:0] adr_put(input logic [AWID-1:0] v, input int idx,
                                              input logic [BYTE_W-1:0] b);
    logic [AWID-1:0] r;
    r = v;
    r[idx*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  logic            sw_touch;
  logic [AWID-1:0] adr_nxt;

  assign sw_touch  = (|cnt_we) | (|adr_we) | cnt_clr;
  assign dec_evt   = strobe & ~sw_touch;
  assign underflow = dec_evt & (cnt == '0);
  assign hit_zero  = dec_evt & (cnt == CW'(1));

  always_comb begin
    cnt_nxt = cnt;
    if (cnt_clr) cnt_nxt = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (cnt_we[i]) cnt_nxt = cnt_put(cnt_nxt, i, wdata);
    end
    if (dec_evt) cnt_nxt = count_down(cnt);
  end

  always_comb begin
    adr_nxt = adr;
    for (int i = 0; i < ADR_BYTES; i++) begin
      if (adr_we[i]) adr_nxt = adr_put(adr_nxt, i, wdata);
    end
    if (dec_evt) adr_nxt = addr_up(adr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      adr <= '0;
    end else begin
      cnt <= cnt_nxt;
      adr <= adr_nxt;
    end
  end
endmodule

// File: rtl/xcu_status.sv
module xcu_status
  import xcu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_touch,
  input  logic                nxt_is_zero,
  input  logic                hit_zero,
  input  logic                underflow,
  input  logic [NUM_FLAG-1:0] w1c,
  output logic                done,
  output logic                wrap
);
  logic load_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pend <= 1'b0;
      done      <= 1'b0;
      wrap      <= 1'b0;
    end else begin
      load_pend <= cnt_touch;
      if (load_pend)         done <= nxt_is_zero;
      else if (hit_zero)     done <= 1'b1;
      else if (w1c[ST_DONE]) done <= 1'b0;
      if (underflow)         wrap <= 1'b1;
      else if (w1c[ST_WRAP]) wrap <= 1'b0;
    end
  end
endmodule

// File: rtl/xcu_regs.sv
module xcu_regs
  import xcu_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int ADR_BYTES = 4,
  parameter int AW        = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [AW-1:0]               reg_addr,
  input  logic [BYTE_W-1:0]           reg_wdata,
  input  logic [CNT_BYTES*BYTE_W-1:0] cnt,
  input  logic [ADR_BYTES*BYTE_W-1:0] adr,
  input  logic                        done,
  input  logic                        wrap,
  output logic [CNT_BYTES-1:0]        cnt_we,
  output logic [ADR_BYTES-1:0]        adr_we,
  output logic                        cnt_clr,
  output logic [NUM_FLAG-1:0]         w1c,
  output logic                        done_ie,
  output logic                        wrap_ie,
  output logic [BYTE_W-1:0]           reg_rdata
);
  localparam int CTL_OFF  = CNT_BYTES;
  localparam int ADR_BASE = CNT_BYTES + 1;
  localparam int STS_OFF  = ADR_BASE + ADR_BYTES;

  logic ctl_hit, sts_hit;

  assign ctl_hit = reg_addr == AW'(CTL_OFF);
  assign sts_hit = reg_addr == AW'(STS_OFF);
  assign cnt_clr = reg_wr & ctl_hit & reg_wdata[CTL_CLR];
  assign w1c     = (reg_wr & sts_hit) ? reg_wdata[NUM_FLAG-1:0] : '0;

  for (genvar g = 0; g < CNT_BYTES; g++) begin : g_cnt_we
    assign cnt_we[g] = reg_wr & (reg_addr == AW'(g));
  end
  for (genvar g = 0; g < ADR_BYTES; g++) begin : g_adr_we
    assign adr_we[g] = reg_wr & (reg_addr == AW'(ADR_BASE + g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_ie <= 1'b0;
      wrap_ie <= 1'b0;
    end else if (reg_wr && ctl_hit) begin
      done_ie <= reg_wdata[CTL_DIE];
      wrap_ie <= reg_wdata[CTL_WIE];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (reg_addr == AW'(i)) reg_rdata = cnt[i*BYTE_W +: BYTE_W];
    end
    for (int i = 0; i < ADR_BYTES; i++) begin
      if (reg_addr == AW'(ADR_BASE + i)) reg_rdata = adr[i*BYTE_W +: BYTE_W];
    end
    if (ctl_hit) begin
      reg_rdata[CTL_DIE] = done_ie;
      reg_rdata[CTL_WIE] = wrap_ie;
    end
    if (sts_hit) begin
      reg_rdata[ST_DONE] = done;
      reg_rdata[ST_WRAP] = wrap;
    end
  end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xcu_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int ADR_BYTES = 4,
  parameter int AW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              byte_done,
  output logic              irq
);
  localparam int CW   = CNT_BYTES * BYTE_W;
  localparam int AWID = ADR_BYTES * BYTE_W;

  logic [CNT_BYTES-1:0] cnt_we;
  logic [ADR_BYTES-1:0] adr_we;
  logic                 cnt_clr;
  logic [NUM_FLAG-1:0]  w1c;
  logic                 done_ie, wrap_ie;
  logic [CW-1:0]        cnt, cnt_nxt;
  logic [AWID-1:0]      adr;
  logic                 dec_evt, hit_zero, underflow;
  logic                 done, wrap;
  logic                 cnt_touch;

  assign cnt_touch = (|cnt_we) | cnt_clr;

  xcu_regs #(.CNT_BYTES(CNT_BYTES), .ADR_BYTES(ADR_BYTES), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt(cnt), .adr(adr), .done(done), .wrap(wrap),
    .cnt_we(cnt_we), .adr_we(adr_we), .cnt_clr(cnt_clr), .w1c(w1c),
    .done_ie(done_ie), .wrap_ie(wrap_ie), .reg_rdata(reg_rdata)
  );

  xcu_counter #(.CNT_BYTES(CNT_BYTES), .ADR_BYTES(ADR_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .adr_we(adr_we),
    .wdata(reg_wdata), .cnt_clr(cnt_clr), .strobe(byte_done),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .adr(adr), .dec_evt(dec_evt),
    .hit_zero(hit_zero), .underflow(underflow)
  );

  xcu_status u_sts (
    .clk(clk), .rst_n(rst_n), .cnt_touch(cnt_touch),
    .nxt_is_zero(cnt_nxt == '0), .hit_zero(hit_zero), .underflow(underflow),
    .w1c(w1c), .done(done), .wrap(wrap)
  );

  assign irq = (done & done_ie) | (wrap & wrap_ie);
endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
  parameter int CW   = 24,
  parameter int AWID = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            byte_done,
  input logic            cnt_touch,
  input logic            dec_evt,
  input logic            hit_zero,
  input logic            underflow,
  input logic [CW-1:0]   cnt,
  input logic [AWID-1:0] adr,
  input logic            done,
  input logic            wrap,
  input logic [1:0]      w1c,
  input logic            done_ie,
  input logic            wrap_ie,
  input logic            irq
);
  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> cnt == $past(cnt) - CW'(1));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_done && !cnt_touch) |=> $stable(cnt));
  p_done_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_zero |=> (done && cnt == '0));
  p_wrap_on_under_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (wrap && cnt == '1));
  p_addr_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> adr == $past(adr) + AWID'(1));
  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c[1] && !underflow) |=> !wrap);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && w1c[1]) |=> wrap);
  p_irq_map_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((done && done_ie) || (wrap && wrap_ie)));
endmodule

bind xfer_count_unit xcu_checker #(.CW(CW), .AWID(AWID)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .cnt_touch(cnt_touch),
  .dec_evt(dec_evt), .hit_zero(hit_zero), .underflow(underflow),
  .cnt(cnt), .adr(adr), .done(done), .wrap(wrap), .w1c(w1c),
  .done_ie(done_ie), .wrap_ie(wrap_ie), .irq(irq)
);

// File: tb/sim_xfer_count_unit.sv
module sim_xfer_count_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // fields: start count, strobes, expected count, done, wrap, start address, expected address
  localparam logic [121:0] VEC [NVEC] = '{
    {24'h000005, 8'd3, 24'h000002, 1'b0, 1'b0, 32'h1000_0000, 32'h1000_0003},
    {24'h000003, 8'd3, 24'h000000, 1'b1, 1'b0, 32'h0000_00FF, 32'h0000_0102},
    {24'h000000, 8'd1, 24'hFFFFFF, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
    {24'h010000, 8'd1, 24'h00FFFF, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0001_0000},
    {24'h000002, 8'd2, 24'h000000, 1'b1, 1'b0, 32'h1234_5678, 32'h1234_567A},
    {24'h000001, 8'd2, 24'hFFFFFF, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0002}
  };

  logic       clk = 0, rst_n = 0, reg_wr = 0, byte_done = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_count_unit u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_done(byte_done), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [23:0] v);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin rd(4'(i), b); v[i*8 +: 8] = b; end
  endtask

  task automatic rd_adr(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(4'(4 + i), b); v[i*8 +: 8] = b; end
  endtask

  task automatic ld_cnt(input logic [23:0] v);
    for (int i = 0; i < 3; i++) wr(4'(i), v[i*8 +: 8]);
  endtask

  task automatic ld_adr(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(4'(4 + i), v[i*8 +: 8]);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_done = 1;
      @(negedge clk); byte_done = 0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [23:0] c;
    logic [31:0] a;
    logic [7:0]  s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    rd_cnt(c); chk("R12 count", 32'(c), 0);
    rd_adr(a); chk("R12 address", a, 0);
    rd(4'd8, s); chk("R12 status", 32'(s), 0);
    rd(4'd3, s); chk("R12 control", 32'(s), 0);
    chk("R12 irq", 32'(irq), 0);

    // table: R1 R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      ld_cnt(VEC[v][121:98]);
      ld_adr(VEC[v][63:32]);
      @(negedge clk);
      wr(4'd8, 8'h03);
      rd_cnt(c); chk("R1 count readback", 32'(c), 32'(VEC[v][121:98]));
      rd_adr(a); chk("R1 address readback", a, VEC[v][63:32]);
      pulse(int'(VEC[v][97:90]));
      rd_cnt(c); chk("R2/R4 count after strobes", 32'(c), 32'(VEC[v][89:66]));
      rd_adr(a); chk("R5 address after strobes", a, VEC[v][31:0]);
      rd(4'd8, s);
      chk("R3 done flag", 32'(s[0]), 32'(VEC[v][65]));
      chk("R4 wrap flag", 32'(s[1]), 32'(VEC[v][64]));
    end

    // R2 no strobe no change
    repeat (3) @(negedge clk);
    rd_cnt(c); chk("R2 hold without strobe", 32'(c), 32'hFFFFFF);

    // R7 clear, R10 recompute one cycle later
    ld_cnt(24'h123456); @(negedge clk); wr(4'd8, 8'h03);
    wr(4'd3, 8'h00);
    rd_cnt(c); chk("R7 bit0 zero keeps count", 32'(c), 32'h123456);
    wr(4'd3, 8'h01);
    rd_cnt(c); chk("R7 clear count", 32'(c), 0);
    rd(4'd8, s); chk("R10 done not yet", 32'(s[0]), 0);
    @(negedge clk);
    rd(4'd8, s); chk("R10 done after recompute", 32'(s[0]), 1);

    // R8 write zero no effect, then write one clears
    wr(4'd8, 8'h00); rd(4'd8, s); chk("R8 zero write no effect", 32'(s[0]), 1);
    wr(4'd8, 8'h01); rd(4'd8, s); chk("R8 one write clears done", 32'(s[0]), 0);

    // R10 load nonzero clears done
    wr(4'd3, 8'h01); @(negedge clk);
    rd(4'd8, s); chk("R10 zero sets done", 32'(s[0]), 1);
    wr(4'd0, 8'h05); @(negedge clk);
    rd(4'd8, s); chk("R10 nonzero load clears done", 32'(s[0]), 0);

    // R9 underflow and wrap clear in same cycle
    wr(4'd3, 8'h01); @(negedge clk); wr(4'd8, 8'h03);
    @(negedge clk); byte_done = 1; reg_wr = 1; reg_addr = 4'd8; reg_wdata = 8'h02;
    @(negedge clk); byte_done = 0; reg_wr = 0;
    rd(4'd8, s); chk("R9 set wins over clear", 32'(s[1]), 1);
    rd_cnt(c); chk("R9 count wrapped", 32'(c), 32'hFFFFFF);

    // R6 strobe collides with software load
    ld_cnt(24'h00000A); ld_adr(32'h0000_0100);
    @(negedge clk); byte_done = 1; reg_wr = 1; reg_addr = 4'd0; reg_wdata = 8'h07;
    @(negedge clk); byte_done = 0; reg_wr = 0;
    rd_cnt(c); chk("R6 count write beats strobe", 32'(c), 32'h7);
    rd_adr(a); chk("R6 address untouched", a, 32'h0000_0100);
    @(negedge clk); byte_done = 1; reg_wr = 1; reg_addr = 4'd4; reg_wdata = 8'h20;
    @(negedge clk); byte_done = 0; reg_wr = 0;
    rd_adr(a); chk("R6 address write beats strobe", a, 32'h0000_0120);
    rd_cnt(c); chk("R6 count untouched", 32'(c), 32'h7);

    // R11 irq masking; wrap=1 from R9, done=0
    wr(4'd8, 8'h01);
    wr(4'd3, 8'h02); chk("R11 done enable only", 32'(irq), 0);
    wr(4'd3, 8'h04); chk("R11 wrap enable", 32'(irq), 1);
    wr(4'd8, 8'h02); chk("R11 wrap cleared", 32'(irq), 0);
    wr(4'd3, 8'h03); @(negedge clk); chk("R11 done enable", 32'(irq), 1);

    finish_run();
  end
endmodule